// File: doc/BRIEF.md
# Level-Sensitive Interrupt and General IO Pin Controller

This block takes four level-sensitive interrupt pins and three general-purpose IO pins. Any of these pins may change with no relation to the clock. Each pin passes through a two-stage synchronizer. The block then compares the synchronized level against a polarity bit and removes the pin if its mask bit is set. A global lock flag suppresses every request at once. The result is registered, so each source has its own request output, and a combined request is the OR of all of them. Requests are plain levels and are never held: when the pin returns to its inactive level, the request goes away.

The synchronized levels of all seven pins are registered into a status word. This word ignores mask, lock and direction, so a masked pin can serve as an ordinary input. Each IO pin has a direction bit. As an input, it acts as a further interrupt source with its own polarity and mask bits. As an output, it drives its polarity bit onto the pad and never raises a request. The pad level that comes back in is still shown in the status word.

Top module: `pin_irq_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low), status_o, src_req_o and req_o are all zero.
- R2: For interrupt pin i, polarity bit 1 means a high level requests and 0 means a low level requests. src_req_o[i] is 1 when the pin level equals irq_pol_i[i], the mask is clear and the lock is clear.
- R3: While lock_i is 1, all of src_req_o and req_o read 0. This takes effect from the first rising edge after lock_i is set.
- R4: A mask bit of 1 keeps that source's src_req_o bit at 0 from the first rising edge after it is set. The source's status bit is not affected.
- R5: A change on any pin appears in src_req_o and status_o exactly at the third rising edge after the change, and not earlier.
- R6: Requests are not latched. A request drops at the third rising edge after its pin returns to the inactive level.
- R7: status_o[3:0] holds the levels of irq_pins_i[3:0] and status_o[6:4] holds the pad levels of gpio_in_i[2:0]. These bits hold whatever the mask, lock and direction settings are.
- R8: An IO pin with gpio_dir_i[k]=0 (input) requests on src_req_o[4+k] under the same rule as R2, using gpio_pol_i[k] and gpio_mask_i[k].
- R9: With gpio_dir_i[k]=1 (output), gpio_oe_o[k] is 1 and gpio_out_o[k] equals gpio_pol_i[k] in the same cycle. With gpio_dir_i[k]=0, gpio_oe_o[k] is 0.
- R10: An IO pin set as an output never sets src_req_o[4+k], even when its level matches its polarity and its mask is clear.
- R11: req_o is the OR of all bits of src_req_o in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_pins_i | input | 4 | Asynchronous interrupt pins |
| gpio_in_i | input | 3 | Pad levels of the IO pins |
| gpio_out_o | output | 3 | Level driven on IO pins set as outputs |
| gpio_oe_o | output | 3 | Output enable per IO pin |
| irq_pol_i | input | 4 | Active level per interrupt pin |
| irq_mask_i | input | 4 | Mask per interrupt pin (1 blocks) |
| gpio_dir_i | input | 3 | Direction per IO pin (1 output) |
| gpio_pol_i | input | 3 | Active level or driven level per IO pin |
| gpio_mask_i | input | 3 | Mask per IO pin (1 blocks) |
| lock_i | input | 1 | Global interrupt lock (1 blocks all) |
| status_o | output | 7 | Synchronized pin levels |
| src_req_o | output | 7 | Request per source |
| req_o | output | 1 | Combined request |

## Verification
The bench steps a single pin edge one cycle at a time. A design with one synchronizer stage too few would show the request a cycle early, and one that stored requests would keep the request high after the pin goes inactive. It drives IO pins as outputs whose looped-back level matches their polarity, which catches a design that lets an output pin interrupt. It also masks and locks pins that are held active, which catches a status path that was wrongly gated by mask or lock. Mixed polarity patterns expose any inversion of the polarity meaning.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
    parameter int unsigned DEF_IRQ_PINS  = 4;
    parameter int unsigned DEF_GPIO_PINS = 3;
    parameter int unsigned DEF_SYNC_DEPTH = 2;

    typedef enum logic {
        PIN_DIR_IN  = 1'b0,
        PIN_DIR_OUT = 1'b1
    } pin_dir_e;

    // A source wants service when its level sits at its active level.
    function automatic logic level_active(input logic level, input logic active_high);
        return level == active_high;
    endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned WIDTH  = 7,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_qualify.sv
module pin_qualify #(
    parameter int unsigned WIDTH = 7
) (
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] pol_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic [WIDTH-1:0] blocked_i,
    input  logic             lock_i,
    output logic [WIDTH-1:0] req_o
);
    import pin_irq_pkg::*;

    for (genvar k = 0; k < int'(WIDTH); k++) begin : g_src
        assign req_o[k] = level_active(level_i[k], pol_i[k])
                          & ~mask_i[k] & ~blocked_i[k] & ~lock_i;
    end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
    parameter int unsigned IRQ_PINS   = pin_irq_pkg::DEF_IRQ_PINS,
    parameter int unsigned GPIO_PINS  = pin_irq_pkg::DEF_GPIO_PINS,
    parameter int unsigned SYNC_DEPTH = pin_irq_pkg::DEF_SYNC_DEPTH,
    localparam int unsigned SRC = IRQ_PINS + GPIO_PINS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IRQ_PINS-1:0]  irq_pins_i,
    input  logic [GPIO_PINS-1:0] gpio_in_i,
    output logic [GPIO_PINS-1:0] gpio_out_o,
    output logic [GPIO_PINS-1:0] gpio_oe_o,
    input  logic [IRQ_PINS-1:0]  irq_pol_i,
    input  logic [IRQ_PINS-1:0]  irq_mask_i,
    input  logic [GPIO_PINS-1:0] gpio_dir_i,
    input  logic [GPIO_PINS-1:0] gpio_pol_i,
    input  logic [GPIO_PINS-1:0] gpio_mask_i,
    input  logic                 lock_i,
    output logic [SRC-1:0]       status_o,
    output logic [SRC-1:0]       src_req_o,
    output logic                 req_o
);
    import pin_irq_pkg::*;

    typedef struct packed {
        logic [SRC-1:0] status;
        logic [SRC-1:0] src_req;
        logic           any_req;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;

    logic [SRC-1:0] level_sync;
    logic [SRC-1:0] pol_all, mask_all, blocked_all, qual_req;

    // Interrupt pins occupy the low bits, IO pins the bits above them.
    pin_sync #(.WIDTH(SRC), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({gpio_in_i, irq_pins_i}),
        .sync_o  (level_sync)
    );

    always_comb begin
        pol_all  = {gpio_pol_i, irq_pol_i};
        mask_all = {gpio_mask_i, irq_mask_i};
        blocked_all = '0;
        for (int g = 0; g < int'(GPIO_PINS); g++) begin
            blocked_all[IRQ_PINS+g] = (gpio_dir_i[g] == PIN_DIR_OUT);
        end
    end

    pin_qualify #(.WIDTH(SRC)) u_qualify (
        .level_i   (level_sync),
        .pol_i     (pol_all),
        .mask_i    (mask_all),
        .blocked_i (blocked_all),
        .lock_i    (lock_i),
        .req_o     (qual_req)
    );

    always_comb begin
        state_d         = state_q;
        state_d.status  = level_sync;
        state_d.src_req = qual_req;
        state_d.any_req = |qual_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        for (int g = 0; g < int'(GPIO_PINS); g++) begin
            gpio_oe_o[g]  = (gpio_dir_i[g] == PIN_DIR_OUT);
            gpio_out_o[g] = gpio_pol_i[g];
        end
    end

    assign status_o  = state_q.status;
    assign src_req_o = state_q.src_req;
    assign req_o     = state_q.any_req;

    // Lock gates every request one edge after it is set.
    assert_lock_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_i) |-> (src_req_o == '0 && !req_o));

    for (genvar k = 0; k < int'(SRC); k++) begin : g_chk
        assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(mask_all[k]) |-> !src_req_o[k]);
        // A raised request means the reported level matched the active level.
        assert_polarity_R2: assert property (@(posedge clk) disable iff (!rst_n)
            src_req_o[k] |-> (status_o[k] == $past(pol_all[k])));
    end

    for (genvar g = 0; g < int'(GPIO_PINS); g++) begin : g_out_chk
        assert_output_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(gpio_dir_i[g]) |-> !src_req_o[IRQ_PINS+g]);
    end
endmodule

// File: tb/pin_irq_ctrl_bench.sv
module pin_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 4;
    localparam int NG = 3;
    localparam int NS = NI + NG;
    localparam int VW = 25;
    localparam int NVEC = 8;

    // irq, ext, ipol, imask, gdir, gpol, gmask, lock
    localparam logic [VW-1:0] VECS [NVEC] = '{
        {4'b1010, 3'b000, 4'b1111, 4'b0000, 3'b000, 3'b000, 3'b000, 1'b0},
        {4'b1010, 3'b101, 4'b0000, 4'b0000, 3'b000, 3'b111, 3'b000, 1'b0},
        {4'b1111, 3'b111, 4'b1111, 4'b1111, 3'b000, 3'b111, 3'b111, 1'b0},
        {4'b0110, 3'b010, 4'b0101, 4'b1000, 3'b001, 3'b011, 3'b100, 1'b0},
        {4'b1010, 3'b000, 4'b1111, 4'b0000, 3'b000, 3'b000, 3'b000, 1'b1},
        {4'b0000, 3'b000, 4'b0000, 4'b0000, 3'b110, 3'b110, 3'b000, 1'b0},
        {4'b1001, 3'b011, 4'b1001, 4'b0110, 3'b000, 3'b010, 3'b001, 1'b0},
        {4'b0001, 3'b100, 4'b0001, 4'b0001, 3'b011, 3'b000, 3'b000, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NI-1:0] irq = '0, ipol = '0, imask = '0;
    logic [NG-1:0] ext = '0, gdir = '0, gpol = '0, gmask = '0;
    logic lock = 1'b0;
    logic [NG-1:0] pad, gout, goe;
    logic [NS-1:0] status, src;
    logic req;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pad loopback: an enabled output wins over the external driver.
    assign pad = (goe & gout) | (~goe & ext);

    pin_irq_ctrl u_pin_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_pins_i(irq), .gpio_in_i(pad),
        .gpio_out_o(gout), .gpio_oe_o(goe), .irq_pol_i(ipol), .irq_mask_i(imask),
        .gpio_dir_i(gdir), .gpio_pol_i(gpol), .gpio_mask_i(gmask), .lock_i(lock),
        .status_o(status), .src_req_o(src), .req_o(req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] model_src();
        logic [NG-1:0] p;
        logic [NS-1:0] r;
        p = (gdir & gpol) | (~gdir & ext);
        for (int i = 0; i < NI; i++) r[i] = (irq[i] == ipol[i]) & ~imask[i] & ~lock;
        for (int k = 0; k < NG; k++) r[NI+k] = ~gdir[k] & (p[k] == gpol[k]) & ~gmask[k] & ~lock;
        return r;
    endfunction

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD*20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NS-1:0] exp_src;
        // R1 reset state, with pins that would otherwise request
        ipol = 4'h0; edges(3);
        check("R1 status", 32'(status), 0);
        check("R1 src", 32'(src), 0);
        check("R1 req", 32'(req), 0);
        irq = '0; ipol = 4'hF; gpol = 3'b111; ext = 3'b000;
        rst_n = 1'b1;
        edges(4);
        check("R2 idle src", 32'(src), 0);

        // R5 latency of a rising pin edge
        irq[0] = 1'b1;
        edges(1); check("R5 edge1 src", 32'(src[0]), 0);
        edges(1); check("R5 edge2 src", 32'(src[0]), 0);
        check("R5 edge2 status", 32'(status[0]), 0);
        edges(1); check("R5 edge3 src", 32'(src[0]), 1);
        check("R5 edge3 status", 32'(status[0]), 1);
        check("R11 req", 32'(req), 1);
        // R6 request drops once the pin is inactive
        irq[0] = 1'b0;
        edges(2); check("R6 edge2 still", 32'(src[0]), 1);
        edges(1); check("R6 edge3 dropped", 32'(src[0]), 0);
        check("R6 req dropped", 32'(req), 0);

        // R3 lock takes effect after one edge; R7 status unaffected
        irq = 4'hF; edges(4);
        check("R2 all high", 32'(src[3:0]), 32'hF);
        lock = 1'b1;
        edges(1);
        check("R3 src locked", 32'(src), 0);
        check("R3 req locked", 32'(req), 0);
        check("R7 status under lock", 32'(status[3:0]), 32'hF);
        lock = 1'b0; irq = '0;

        // R9 output enable and driven level, same cycle
        gdir = 3'b101; gpol = 3'b001;
        #1;
        check("R9 oe", 32'(goe), 32'h5);
        check("R9 out", 32'(gout & goe), 32'h1);
        gdir = 3'b000;
        #1;
        check("R9 oe off", 32'(goe), 0);

        // R10 outputs matching their polarity stay silent
        gdir = 3'b111; gpol = 3'b111; gmask = 3'b000; ext = 3'b000;
        edges(3);
        check("R10 status io", 32'(status[6:4]), 32'h7);
        check("R10 src io", 32'(src[6:4]), 0);
        check("R10 req", 32'(req), 0);

        // Table walk: R2 R4 R7 R8 R10 R11
        for (int v = 0; v < NVEC; v++) begin
            {irq, ext, ipol, imask, gdir, gpol, gmask, lock} = VECS[v];
            exp_src = model_src();
            edges(3);
            check($sformatf("R2/R4/R8/R10 src vec%0d", v), 32'(src), 32'(exp_src));
            check($sformatf("R7 status vec%0d", v), 32'(status),
                  32'({(gdir & gpol) | (~gdir & ext), irq}));
            check($sformatf("R11 req vec%0d", v), 32'(req), 32'(|exp_src));
            check($sformatf("R9 oe vec%0d", v), 32'(goe), 32'(gdir));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule